// File: doc/BRIEF.md
# Memory-Mapped PCI Configuration Window Decoder

This block answers a plain processor-side bus and turns accesses inside a 4 MiB address window into PCI configuration requests. The window offset is not sent as it is. The lowest set bit among eleven one-hot select bits (offset bits 11 to 21) is priority-encoded into a five-bit device number. The function number and register offset bits pass through below it. Data travels little-endian. Bus-side data is right-justified, and the block moves it onto the correct byte lanes of the configuration data path, then takes read data back off them.

A single byte location near the top of the address map serves as an interrupt-acknowledge port. A byte read there raises a handshake towards the interrupt controller and returns the vector it supplies. Any other access to that location completes at once with an error and zero data. The block also folds four level-sensitive PCI interrupt pins of one device onto the interrupt lines with a fixed rotation that depends on the device number.

Each request is held until its acknowledge arrives. Bus ready then pulses for one cycle, carrying the result.

Top module: `pci_cfg_window`

## Requirements
- R1: An access is claimed (`bus_claim` high) only when `bus_addr` lies in 0x8080_0000..0x80BF_FFFF or equals 0xBFFF_FFF0. An unclaimed access raises neither `cfg_req` nor `inta_req`, and `bus_ready` stays low.
- R2: `cfg_addr[15:11]` holds the index (0 to 10) of the lowest set bit among offset bits 11 to 21. Higher set bits are ignored.
- R3: When none of offset bits 11 to 21 is set, `cfg_addr[15:11]` is 11.
- R4: `cfg_addr[10:0]` equals offset bits [10:0], and `cfg_addr` and `cfg_be` stay stable while `cfg_req` waits for `cfg_ack`.
- R5: `bus_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. The lane is `bus_addr[1:0]` for bytes, `{bus_addr[1],0}` for halves and 0 for words. `cfg_be` is the size mask shifted left by the lane. `cfg_wdata` is the right-justified `bus_wdata`, masked to the size and shifted left by 8 times the lane.
- R6: On a configuration read, `cfg_rdata` is shifted right by 8 times the lane, masked to the size and latched in the cycle of `cfg_ack`. `bus_ready` is high for exactly the one following cycle with that value on `bus_rdata`. A write returns zero.
- R7: `cfg_req` rises the cycle after a claimed window access is seen and stays high until `cfg_ack`. `bus_ready` is low while `cfg_req` is high.
- R8: A one-byte read of 0xBFFF_FFF0 raises `inta_req` until `inta_ack`. The `inta_vec` present with the acknowledge then returns zero-extended on `bus_rdata`, with `bus_err` low.
- R9: Any write, or any read wider than a byte, to 0xBFFF_FFF0 raises no `inta_req`. It completes with `bus_err` high and `bus_rdata` zero on the next cycle.
- R10: `irq_line[j]` (j = 0, 1) is the OR of every `pci_int[n]` with (n + `irq_dev`) mod 2 = j. The lines are level-sensitive and combinational.
- R11: `irq_line[3:2]` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Right-justified write data |
| bus_claim | output | 1 | Access falls in a decoded location |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with `bus_ready` |
| bus_rdata | output | 32 | Right-justified read data, valid with `bus_ready` |
| cfg_req | output | 1 | Configuration request |
| cfg_write | output | 1 | Configuration write flag |
| cfg_addr | output | 16 | Device, function and register address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Configuration acknowledge |
| cfg_rdata | input | 32 | Lane-aligned read data, valid with `cfg_ack` |
| inta_req | output | 1 | Interrupt-acknowledge request |
| inta_ack | input | 1 | Interrupt controller acknowledge |
| inta_vec | input | 8 | Vector, valid with `inta_ack` |
| pci_int | input | 4 | Level interrupt pins of one device |
| irq_dev | input | 5 | Device number of that device |
| irq_line | output | 4 | Routed interrupt lines |

## Verification
The hardest state to reach from the ports is a configuration request kept waiting for several cycles. Address and byte enables must stay frozen during the wait while bus ready stays low. Reaching it needs a responder that withholds `cfg_ack`. The bench's configuration responder takes a per-item delay from the scoreboard queue. It checks ready and request on every waiting cycle. It crosses those delays with odd lane offsets, misaligned halfword accesses and select fields that carry several set bits, so that the priority and masking paths are exercised while the request is stalled.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_INTA = 2'd2,
    ST_DONE = 2'd3
  } pcw_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/pcw_dev_encode.sv
module pcw_dev_encode #(
  parameter int SEL_LSB  = 11,
  parameter int SEL_BITS = 11,
  parameter int DEV_W    = 5,
  parameter int OFF_W    = SEL_LSB + SEL_BITS,
  parameter int CFG_AW   = SEL_LSB + DEV_W
) (
  input  logic [OFF_W-1:0]  offset,
  output logic [CFG_AW-1:0] cfg_addr
);
  logic [DEV_W-1:0] dev;

  // scan from the top so the lowest set select bit wins
  always_comb begin
    dev = DEV_W'(SEL_BITS);
    for (int i = SEL_BITS - 1; i >= 0; i--) begin
      if (offset[SEL_LSB + i]) dev = DEV_W'(i);
    end
  end

  assign cfg_addr = {dev, offset[SEL_LSB-1:0]};
endmodule

// File: rtl/pcw_lane.sv
module pcw_lane #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [1:0]    size,
  input  logic [LW-1:0] addr_lo,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  output logic [NB-1:0] be,
  output logic [DW-1:0] wdata_out,
  output logic [DW-1:0] rdata_out
);
  import pcw_pkg::*;

  logic [NB-1:0] base;
  logic [LW-1:0] lane;
  logic [DW-1:0] dmask;
  logic [LW+2:0] sh;

  always_comb begin
    case (size)
      SZ_BYTE: begin base = NB'(1); lane = addr_lo;             end
      SZ_HALF: begin base = NB'(3); lane = addr_lo & ~LW'(1);   end
      default: begin base = '1;     lane = '0;                  end
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign dmask[b*8 +: 8] = {8{base[b]}};
  end

  assign sh        = {lane, 3'b000};
  assign be        = base << lane;
  assign wdata_out = (wdata_in & dmask) << sh;
  assign rdata_out = (rdata_in >> sh) & dmask;
endmodule

// File: rtl/pcw_irq_swizzle.sv
module pcw_irq_swizzle #(
  parameter int NPIN  = 4,
  parameter int NLINE = 4,
  parameter int ROUTE = 2,
  parameter int DEV_W = 5
) (
  input  logic [NPIN-1:0]  pin,
  input  logic [DEV_W-1:0] dev,
  output logic [NLINE-1:0] line
);
  for (genvar L = 0; L < NLINE; L++) begin : g_line
    if (L < ROUTE) begin : g_used
      always_comb begin
        line[L] = 1'b0;
        for (int k = 0; k < NPIN; k++) begin
          if (((k + int'(dev)) % ROUTE) == L) line[L] = line[L] | pin[k];
        end
      end
    end else begin : g_idle
      assign line[L] = 1'b0;
    end
  end
endmodule

// File: rtl/pci_cfg_window.sv
module pci_cfg_window #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          WIN_LOG2  = 22,
  parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
  parameter logic [31:0] INTA_ADDR = 32'hBFFF_FFF0,
  parameter int          SEL_LSB   = 11,
  parameter int          DEV_W     = 5,
  parameter int          VEC_W     = 8,
  parameter int          NPIN      = 4,
  parameter int          NLINE     = 4,
  localparam int         NB        = DW / 8,
  localparam int         SEL_BITS  = WIN_LOG2 - SEL_LSB,
  localparam int         CFG_AW    = SEL_LSB + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_claim,
  output logic              bus_ready,
  output logic              bus_err,
  output logic [DW-1:0]     bus_rdata,
  output logic              cfg_req,
  output logic              cfg_write,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [NB-1:0]     cfg_be,
  output logic [DW-1:0]     cfg_wdata,
  input  logic              cfg_ack,
  input  logic [DW-1:0]     cfg_rdata,
  output logic              inta_req,
  input  logic              inta_ack,
  input  logic [VEC_W-1:0]  inta_vec,
  input  logic [NPIN-1:0]   pci_int,
  input  logic [DEV_W-1:0]  irq_dev,
  output logic [NLINE-1:0]  irq_line
);
  import pcw_pkg::*;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  // address decode
  logic cfg_hit, ia_hit;
  assign cfg_hit   = bus_addr[AW-1:WIN_LOG2] == WIN_BASE[AW-1:WIN_LOG2];
  assign ia_hit    = bus_addr == INTA_ADDR[AW-1:0];
  assign bus_claim = bus_valid & (cfg_hit | ia_hit);

  // state and captured access
  pcw_state_e          st_q, st_d;
  logic [WIN_LOG2-1:0] off_q;
  logic [1:0]          size_q;
  logic                wr_q;
  logic [DW-1:0]       wdata_q;
  logic [DW-1:0]       rdata_q, rdata_d;
  logic                err_q, err_d;
  logic                cap, upd;
  logic [DW-1:0]       lane_rdata;

  always_comb begin
    st_d    = st_q;
    cap     = 1'b0;
    upd     = 1'b0;
    rdata_d = rdata_q;
    err_d   = err_q;
    case (st_q)
      ST_IDLE: begin
        if (bus_valid && cfg_hit) begin
          st_d    = ST_CFG;
          cap     = 1'b1;
          upd     = 1'b1;
          rdata_d = '0;
          err_d   = 1'b0;
        end else if (bus_valid && ia_hit) begin
          cap     = 1'b1;
          upd     = 1'b1;
          rdata_d = '0;
          if (!bus_write && bus_size == SZ_BYTE) begin
            st_d  = ST_INTA;
            err_d = 1'b0;
          end else begin
            st_d  = ST_DONE;
            err_d = 1'b1;
          end
        end
      end
      ST_CFG: begin
        if (cfg_ack) begin
          st_d = ST_DONE;
          if (!wr_q) begin
            upd     = 1'b1;
            rdata_d = lane_rdata;
          end
        end
      end
      ST_INTA: begin
        if (inta_ack) begin
          st_d    = ST_DONE;
          upd     = 1'b1;
          rdata_d = DW'(inta_vec);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= ST_IDLE;
      off_q   <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap) begin
        off_q   <= bus_addr[WIN_LOG2-1:0];
        size_q  <= bus_size;
        wr_q    <= bus_write;
        wdata_q <= bus_wdata;
      end
      if (upd) begin
        rdata_q <= rdata_d;
        err_q   <= err_d;
      end
    end
  end

  pcw_dev_encode #(
    .SEL_LSB (SEL_LSB),
    .SEL_BITS(SEL_BITS),
    .DEV_W   (DEV_W)
  ) u_enc (
    .offset  (off_q),
    .cfg_addr(cfg_addr)
  );

  pcw_lane #(
    .DW(DW)
  ) u_lane (
    .size     (size_q),
    .addr_lo  (off_q[$clog2(NB)-1:0]),
    .wdata_in (wdata_q),
    .rdata_in (cfg_rdata),
    .be       (cfg_be),
    .wdata_out(cfg_wdata),
    .rdata_out(lane_rdata)
  );

  pcw_irq_swizzle #(
    .NPIN (NPIN),
    .NLINE(NLINE),
    .ROUTE(2),
    .DEV_W(DEV_W)
  ) u_irq (
    .pin (pci_int),
    .dev (irq_dev),
    .line(irq_line)
  );

  assign cfg_req   = st_q == ST_CFG;
  assign cfg_write = wr_q;
  assign inta_req  = st_q == ST_INTA;
  assign bus_ready = st_q == ST_DONE;
  assign bus_err   = bus_ready & err_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic        bus_err,
  input logic [31:0] bus_rdata,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [15:0] cfg_addr,
  input logic [3:0]  cfg_be,
  input logic        inta_req,
  input logic [3:0]  pci_int,
  input logic [3:0]  irq_line
);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req);

  assert_no_ready_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !bus_ready);

  assert_req_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(bus_valid));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_be));

  assert_be_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_be != 4'b0000);

  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready && bus_err |-> bus_rdata == 32'h0);

  assert_one_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cfg_req, inta_req, bus_ready}) <= 1);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_int == 4'b0000 |-> irq_line == 4'b0000);

  assert_irq_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_int != 4'b0000 |-> irq_line[1:0] != 2'b00);
endmodule

bind pci_cfg_window pcw_checker u_pcw_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_err  (bus_err),
  .bus_rdata(bus_rdata),
  .cfg_req  (cfg_req),
  .cfg_ack  (cfg_ack),
  .cfg_addr (cfg_addr),
  .cfg_be   (cfg_be),
  .inta_req (inta_req),
  .pci_int  (pci_int),
  .irq_line (irq_line)
);

// File: tb/test_pci_cfg_window.sv
`timescale 1ns/1ps
module test_pci_cfg_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic        bus_claim, bus_ready, bus_err;
  logic [31:0] bus_rdata;
  logic        cfg_req, cfg_write, cfg_ack;
  logic [15:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        inta_req, inta_ack;
  logic [7:0]  inta_vec;
  logic [3:0]  pci_int, irq_line;
  logic [4:0]  irq_dev;

  always #2 clk = ~clk;

  pci_cfg_window i_pci_cfg_window (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_claim(bus_claim),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
    .cfg_rdata(cfg_rdata), .inta_req(inta_req), .inta_ack(inta_ack),
    .inta_vec(inta_vec), .pci_int(pci_int), .irq_dev(irq_dev),
    .irq_line(irq_line)
  );

  int checks = 0;
  int bad    = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        wr;
    logic [31:0] rdata;
    int          delay;
  } cfg_item_t;

  cfg_item_t exp_q[$];
  int        inta_seen = 0;
  logic [7:0] vec_next = 8'h00;

  // expected configuration address from the select rule
  function automatic logic [15:0] f_cfg(input logic [31:0] a);
    int d = 11;
    for (int i = 0; i < 11; i++) begin
      if (a[11 + i]) begin
        d = i;
        break;
      end
    end
    return {5'(d), a[10:0]};
  endfunction

  // monitor / responder on the configuration side
  initial begin
    cfg_item_t it;
    cfg_ack   = 1'b0;
    cfg_rdata = '0;
    forever begin
      @(negedge clk);
      if (cfg_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected cfg_req", 32'(cfg_addr), 32'h0);
          it = '{addr: 16'h0, be: 4'h0, wdata: 32'h0, wr: 1'b0, rdata: 32'h0, delay: 0};
        end else begin
          it = exp_q.pop_front();
          chk(cfg_addr == it.addr, "R2/R3/R4 cfg_addr", 32'(cfg_addr), 32'(it.addr));
          chk(cfg_be == it.be, "R5 cfg_be", 32'(cfg_be), 32'(it.be));
          chk(cfg_write == it.wr, "R7 cfg_write", 32'(cfg_write), 32'(it.wr));
          if (it.wr) chk(cfg_wdata == it.wdata, "R5 cfg_wdata", cfg_wdata, it.wdata);
        end
        for (int d = 0; d < it.delay; d++) begin
          @(negedge clk);
          chk(cfg_req && !bus_ready, "R7 wait holds", {30'h0, cfg_req, bus_ready}, 32'h2);
          chk(cfg_addr == it.addr, "R4 addr stable", 32'(cfg_addr), 32'(it.addr));
        end
        cfg_ack   = 1'b1;
        cfg_rdata = it.rdata;
        @(negedge clk);
        cfg_ack   = 1'b0;
        cfg_rdata = 32'hDEAD_BEEF;
      end
    end
  end

  // interrupt controller responder
  initial begin
    inta_ack = 1'b0;
    inta_vec = '0;
    forever begin
      @(negedge clk);
      if (inta_req) begin
        inta_seen++;
        @(negedge clk);
        inta_ack = 1'b1;
        inta_vec = vec_next;
        @(negedge clk);
        inta_ack = 1'b0;
        inta_vec = 8'hFF;
      end
    end
  end

  task automatic bus_op(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, output logic claim, output logic got,
                        output logic [31:0] rd, output logic er);
    bus_addr  = a;
    bus_size  = sz;
    bus_write = wr;
    bus_wdata = wd;
    bus_valid = 1'b1;
    #1 claim = bus_claim;
    got = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      if (bus_ready) got = 1'b1;
    end
    rd = bus_rdata;
    er = bus_err;
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_op(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input logic [3:0] ebe,
                        input logic [31:0] ewd, input logic [31:0] resp,
                        input logic [31:0] erd, input int dly, input string rq);
    logic claim, got, er;
    logic [31:0] rd;
    exp_q.push_back('{addr: f_cfg(a), be: ebe, wdata: ewd, wr: wr, rdata: resp, delay: dly});
    bus_op(a, sz, wr, wd, claim, got, rd, er);
    chk(claim, {rq, " R1 claim"}, 32'(claim), 32'h1);
    chk(got && !er, {rq, " R6 ready"}, {30'h0, got, er}, 32'h2);
    chk(rd == erd, {rq, " R6 rdata"}, rd, erd);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic claim, got, er;
    logic [31:0] rd;
    logic [3:0]  eline;
    logic [3:0]  pats [7] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h5, 4'hF};
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    pci_int = '0; irq_dev = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk(!cfg_req && !inta_req && !bus_ready && irq_line == 0, "reset R7",
        {27'h0, cfg_req, inta_req, bus_ready, 2'b0}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: each select bit alone, word reads with varying waits
    for (int i = 0; i < 11; i++) begin
      cfg_op(32'h8080_0000 | (32'h1 << (11 + i)) | 32'(i * 4), 2'd2, 1'b0, 32'h0,
             4'hF, 32'h0, 32'h1000_0000 + 32'(i), 32'h1000_0000 + 32'(i), i % 4, "R2");
    end
    // R2: several select bits, lowest wins
    cfg_op(32'h8080_0000 | (32'h1 << 13) | (32'h1 << 18) | 32'h7FC, 2'd2, 1'b0, 32'h0,
           4'hF, 32'h0, 32'hCAFE_F00D, 32'hCAFE_F00D, 2, "R2 multi");
    cfg_op(32'h80BF_F800, 2'd2, 1'b0, 32'h0, 4'hF, 32'h0, 32'h1, 32'h1, 0, "R2 all");
    // R3: no select bit
    cfg_op(32'h8080_0104, 2'd2, 1'b0, 32'h0, 4'hF, 32'h0, 32'h5555_AAAA, 32'h5555_AAAA,
           1, "R3");
    // R4: function and register bits
    cfg_op(32'h8080_27FC, 2'd2, 1'b0, 32'h0, 4'hF, 32'h0, 32'h0BAD_CAFE, 32'h0BAD_CAFE,
           3, "R4");
    // R5: byte write lane 3 with garbage above the byte
    cfg_op(32'h8080_1003, 2'd0, 1'b1, 32'hFFFF_FF5A, 4'h8, 32'h5A00_0000, 32'h0, 32'h0,
           1, "R5 byte wr");
    // R5: misaligned halfword write snaps to lane 2
    cfg_op(32'h8080_0803, 2'd1, 1'b1, 32'hABCD_1234, 4'hC, 32'h1234_0000, 32'h0, 32'h0,
           0, "R5 half wr");
    // R5: word write with low address bits set uses lane 0
    cfg_op(32'h8080_4002, 2'd2, 1'b1, 32'h8765_4321, 4'hF, 32'h8765_4321, 32'h0, 32'h0,
           2, "R5 word wr");
    // R6: halfword read lane 2, byte read lane 1, size code 3
    cfg_op(32'h8080_0802, 2'd1, 1'b0, 32'h0, 4'hC, 32'h0, 32'hAABB_CCDD, 32'h0000_AABB,
           2, "R6 half rd");
    cfg_op(32'h8080_0801, 2'd0, 1'b0, 32'h0, 4'h2, 32'h0, 32'hAABB_CCDD, 32'h0000_00CC,
           0, "R6 byte rd");
    cfg_op(32'h8080_0800, 2'd3, 1'b0, 32'h0, 4'hF, 32'h0, 32'h0102_0304, 32'h0102_0304,
           1, "R6 size3");

    // R1: unclaimed neighbours
    bus_op(32'h80C0_0000, 2'd2, 1'b0, 32'h0, claim, got, rd, er);
    chk(!claim && !got, "R1 above window", {30'h0, claim, got}, 32'h0);
    bus_op(32'h807F_FFFC, 2'd2, 1'b1, 32'h1, claim, got, rd, er);
    chk(!claim && !got, "R1 below window", {30'h0, claim, got}, 32'h0);
    bus_op(32'hBFFF_FFF1, 2'd0, 1'b0, 32'h0, claim, got, rd, er);
    chk(!claim && !got, "R1 next to intack", {30'h0, claim, got}, 32'h0);

    // R8: interrupt acknowledge byte read
    vec_next = 8'h2B;
    bus_op(32'hBFFF_FFF0, 2'd0, 1'b0, 32'h0, claim, got, rd, er);
    chk(claim && got && !er, "R8 handshake", {29'h0, claim, got, er}, 32'h6);
    chk(rd == 32'h2B, "R8 vector", rd, 32'h2B);
    chk(inta_seen == 1, "R8 one request", 32'(inta_seen), 32'h1);
    // R9: wider read and a write
    bus_op(32'hBFFF_FFF0, 2'd2, 1'b0, 32'h0, claim, got, rd, er);
    chk(claim && got && er && rd == 0, "R9 word read", rd, 32'h0);
    bus_op(32'hBFFF_FFF0, 2'd0, 1'b1, 32'h77, claim, got, rd, er);
    chk(claim && got && er && rd == 0, "R9 write", {29'h0, claim, got, er}, 32'h7);
    chk(inta_seen == 1, "R9 no request", 32'(inta_seen), 32'h1);

    // R10 / R11: interrupt routing
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 7; p++) begin
        irq_dev = 5'(d * 7);
        pci_int = pats[p];
        eline = '0;
        for (int k = 0; k < 4; k++) if (pats[p][k]) eline[(k + d * 7) % 2] = 1'b1;
        @(negedge clk);
        chk(irq_line[1:0] == eline[1:0], "R10 swizzle", 32'(irq_line), 32'(eline));
        chk(irq_line[3:2] == 2'b00, "R11 upper lines", 32'(irq_line), 32'(eline));
      end
    end
    pci_int = '0;

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all requests seen", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule